// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small fully associative store that sits next to a direct-mapped primary cache and keeps the blocks that cache throws out. Primary hits never reach it, so the primary hit path keeps its direct-mapped timing. When the primary cache misses, it presents the missing block address on the lookup port. In the same cycle it presents the block it is about to displace on the eviction port. Every entry is compared with the lookup address at once.

When the lookup hits, the stored block is handed back on the response port and the displaced primary block takes its slot, so no lower-memory access is needed. When the lookup misses, a read request is raised towards lower memory. The displaced block then goes into the slot chosen by a round-robin insertion pointer. If that pushes out a modified entry, the old entry is sent on the write-back port.

The eviction port may also be used without a lookup. An address that is already held is overwritten in place, so the store never holds one address twice. All responses appear one clock after the request.

Top module: `victim_cache`

## Requirements
- R1: A synchronous active-high reset invalidates every entry, returns the insertion pointer to slot 0, and drives rsp_valid, rsp_hit, mem_req_valid and wb_valid low. A lookup right after reset misses.
- R2: A lookup is made only in a cycle with lk_valid high. rsp_valid is high in the following cycle exactly when lk_valid was high.
- R3: If any valid entry holds lk_addr, the next cycle shows rsp_hit=1, the entry's data on rsp_data, its modified flag on rsp_dirty, and mem_req_valid=0.
- R4: If no valid entry holds lk_addr, the next cycle shows rsp_hit=0, mem_req_valid=1 and mem_req_addr equal to lk_addr.
- R5: An entry that satisfied a lookup is handed out and leaves the store. A second lookup of the same address misses, unless the same cycle re-inserted it.
- R6: When a lookup hits and ev_valid is high, the displaced block (ev_addr, ev_data, ev_dirty) takes the hit entry's slot. The insertion pointer does not move and no write-back occurs.
- R7: An eviction whose address is not held, in a cycle with no lookup hit, is written at the insertion pointer. The pointer then advances by one modulo 4. After five distinct inserts the first one is gone.
- R8: If an R7 insert overwrites a valid entry whose modified flag is set, the next cycle shows wb_valid=1 with that entry's address and data. A clean or invalid slot gives wb_valid=0.
- R9: An eviction whose address is already held overwrites that entry in place. The new data is taken, the modified flag becomes the OR of old and new, the pointer does not move and no write-back occurs. No two valid entries ever share an address.
- R10: The eviction port works alone, with lk_valid low. It follows R7 to R9 and produces no response.
- R11: rsp_valid, mem_req_valid and wb_valid are single-cycle pulses. After a cycle with neither lookup nor eviction, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Primary-miss lookup request |
| lk_addr | input | 16 | Block address being looked up |
| ev_valid | input | 1 | Block displaced from the primary cache is offered |
| ev_addr | input | 16 | Address of the displaced block |
| ev_data | input | 32 | Data of the displaced block |
| ev_dirty | input | 1 | Displaced block is modified |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup found the block |
| rsp_data | output | 32 | Block data returned on a hit |
| rsp_dirty | output | 1 | Modified flag of the returned block |
| mem_req_valid | output | 1 | Read request to lower memory |
| mem_req_addr | output | 16 | Block address to read |
| wb_valid | output | 1 | Write-back of a modified entry pushed out |
| wb_addr | output | 16 | Address of the written-back block |
| wb_data | output | 32 | Data of the written-back block |

## Verification
Directed sequences come first. A lookup straight after reset checks the cold miss. Four inserts followed by lookups show that every slot is searched. A repeated lookup shows that an entry leaves once it is handed out. Two more inserts wrap the pointer, pushing out first an emptied slot and then a modified one, which separates the write-back case from the silent overwrite. Re-offering a held address with changed data and flag shows the in-place merge rather than a second copy. A hit combined with an eviction shows the swap without pointer movement. Random traffic over twelve addresses, three times the capacity, then mixes lookups and evictions in the same cycle, including an eviction of the very address being looked up. An idle cycle between some operations shows that the response, memory request and write-back outputs are pulses.

// File: rtl/vc_pkg.sv
package vc_pkg;
    localparam int VC_ENTRIES = 4;
    localparam int VC_ADDR_W  = 16;
    localparam int VC_DATA_W  = 32;
    localparam int VC_IDX_W   = (VC_ENTRIES > 1) ? $clog2(VC_ENTRIES) : 1;

    typedef logic [VC_ADDR_W-1:0] blk_addr_t;
    typedef logic [VC_DATA_W-1:0] blk_data_t;
    typedef logic [VC_IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic      valid;
        logic      dirty;
        blk_addr_t addr;
        blk_data_t data;
    } vc_entry_t;

    function automatic idx_t onehot_to_idx(input logic [VC_ENTRIES-1:0] oh);
        idx_t r;
        r = '0;
        for (int k = 0; k < VC_ENTRIES; k++) begin
            if (oh[k]) r = idx_t'(k);
        end
        return r;
    endfunction

    function automatic idx_t ring_next(input idx_t p, input int n);
        if (p == idx_t'(n - 1)) return '0;
        return p + idx_t'(1);
    endfunction
endpackage

// File: rtl/vc_match.sv
module vc_match
    import vc_pkg::*;
#(
    parameter int N = VC_ENTRIES
) (
    input  vc_entry_t        ent [N],
    input  logic             key_en,
    input  blk_addr_t        key,
    output logic [N-1:0]     hit_vec,
    output logic             any_hit,
    output idx_t             hit_idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = key_en && ent[g].valid && (ent[g].addr == key);
    end

    assign any_hit = |hit_vec;
    assign hit_idx = onehot_to_idx(hit_vec);
endmodule

// File: rtl/vc_repl_ptr.sv
module vc_repl_ptr
    import vc_pkg::*;
#(
    parameter int N = VC_ENTRIES
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output idx_t ptr
);
    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= ring_next(ptr, N);
    end

    assert_ptr_range_R7: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < N);

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr));
endmodule

// File: rtl/vc_entry_array.sv
module vc_entry_array
    import vc_pkg::*;
#(
    parameter int N = VC_ENTRIES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr_en,
    input  idx_t      clr_idx,
    input  logic      wr_en,
    input  idx_t      wr_idx,
    input  vc_entry_t wr_entry,
    output vc_entry_t ent [N]
);
    logic [N-1:0] valid_vec;

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else if (wr_en && wr_idx == idx_t'(g)) begin
                ent[g] <= wr_entry;
            end else if (clr_en && clr_idx == idx_t'(g)) begin
                ent[g].valid <= 1'b0;
            end
        end
        assign valid_vec[g] = ent[g].valid;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (valid_vec == '0));
endmodule

// File: rtl/victim_cache.sv
module victim_cache
    import vc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_valid,
    input  logic [VC_ADDR_W-1:0] lk_addr,
    input  logic                 ev_valid,
    input  logic [VC_ADDR_W-1:0] ev_addr,
    input  logic [VC_DATA_W-1:0] ev_data,
    input  logic                 ev_dirty,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [VC_DATA_W-1:0] rsp_data,
    output logic                 rsp_dirty,
    output logic                 mem_req_valid,
    output logic [VC_ADDR_W-1:0] mem_req_addr,
    output logic                 wb_valid,
    output logic [VC_ADDR_W-1:0] wb_addr,
    output logic [VC_DATA_W-1:0] wb_data
);
    vc_entry_t             ent [VC_ENTRIES];
    logic [VC_ENTRIES-1:0] lk_vec, ev_vec;
    logic                  lk_hit, ev_hit;
    idx_t                  lk_idx, ev_idx, ptr;
    logic                  clr_en, wr_en, adv, push_wb;
    idx_t                  wr_idx;
    vc_entry_t             wr_entry, hit_ent, out_ent;

    vc_match #(.N(VC_ENTRIES)) u_lk_match (
        .ent(ent), .key_en(lk_valid), .key(lk_addr),
        .hit_vec(lk_vec), .any_hit(lk_hit), .hit_idx(lk_idx)
    );

    vc_match #(.N(VC_ENTRIES)) u_ev_match (
        .ent(ent), .key_en(ev_valid), .key(ev_addr),
        .hit_vec(ev_vec), .any_hit(ev_hit), .hit_idx(ev_idx)
    );

    vc_repl_ptr #(.N(VC_ENTRIES)) u_ptr (
        .clk(clk), .rst(rst), .adv(adv), .ptr(ptr)
    );

    vc_entry_array #(.N(VC_ENTRIES)) u_store (
        .clk(clk), .rst(rst),
        .clr_en(clr_en), .clr_idx(lk_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
        .ent(ent)
    );

    // Placement of the offered block: merge, swap, or round-robin insert.
    always_comb begin
        hit_ent  = ent[lk_idx];
        out_ent  = ent[ptr];
        clr_en   = lk_hit;
        wr_en    = 1'b0;
        adv      = 1'b0;
        push_wb  = 1'b0;
        wr_idx   = ptr;
        wr_entry = '{valid: 1'b1, dirty: ev_dirty, addr: ev_addr, data: ev_data};
        if (ev_valid) begin
            wr_en = 1'b1;
            if (ev_hit) begin
                wr_idx         = ev_idx;
                wr_entry.dirty = ev_dirty | ent[ev_idx].dirty;
            end else if (lk_hit) begin
                wr_idx = lk_idx;
            end else begin
                adv     = 1'b1;
                push_wb = out_ent.valid & out_ent.dirty;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_data      <= '0;
            rsp_dirty     <= 1'b0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            wb_valid      <= 1'b0;
            wb_addr       <= '0;
            wb_data       <= '0;
        end else begin
            rsp_valid     <= lk_valid;
            rsp_hit       <= lk_hit;
            rsp_data      <= lk_hit ? hit_ent.data : '0;
            rsp_dirty     <= lk_hit & hit_ent.dirty;
            mem_req_valid <= lk_valid & ~lk_hit;
            mem_req_addr  <= lk_addr;
            wb_valid      <= push_wb;
            wb_addr       <= out_ent.addr;
            wb_data       <= out_ent.data;
        end
    end

    logic dup_c;
    always_comb begin
        dup_c = 1'b0;
        for (int i = 0; i < VC_ENTRIES; i++) begin
            for (int j = i + 1; j < VC_ENTRIES; j++) begin
                if (ent[i].valid && ent[j].valid && ent[i].addr == ent[j].addr)
                    dup_c = 1'b1;
            end
        end
    end

    assert_no_dup_R9: assert property (@(posedge clk) disable iff (rst)
        !dup_c);

    assert_match_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec) && $onehot0(ev_vec));

    assert_miss_request_R4: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_hit) |=> (mem_req_valid && !rsp_hit && mem_req_addr == $past(lk_addr)));

    assert_hit_no_request_R3: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_hit) |=> (rsp_hit && !mem_req_valid));

    assert_wb_from_insert_R8: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> ($past(ev_valid) && !$past(ev_hit) && !$past(lk_hit)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!lk_valid && !ev_valid) |=> (!rsp_valid && !mem_req_valid && !wb_valid));

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(lk_valid));
endmodule

// File: tb/victim_cache_tb.sv
module victim_cache_tb;
    import vc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = VC_ENTRIES;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 lk_valid = 1'b0;
    logic [VC_ADDR_W-1:0] lk_addr = '0;
    logic                 ev_valid = 1'b0;
    logic [VC_ADDR_W-1:0] ev_addr = '0;
    logic [VC_DATA_W-1:0] ev_data = '0;
    logic                 ev_dirty = 1'b0;
    logic                 rsp_valid, rsp_hit, rsp_dirty;
    logic [VC_DATA_W-1:0] rsp_data;
    logic                 mem_req_valid, wb_valid;
    logic [VC_ADDR_W-1:0] mem_req_addr, wb_addr;
    logic [VC_DATA_W-1:0] wb_data;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // Bench reference model of the store
    bit                   m_v [N];
    bit                   m_y [N];
    logic [VC_ADDR_W-1:0] m_a [N];
    logic [VC_DATA_W-1:0] m_d [N];
    int                   m_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    victim_cache u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data), .ev_dirty(ev_dirty),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int find(input logic [VC_ADDR_W-1:0] a);
        for (int k = 0; k < N; k++) begin
            if (m_v[k] && m_a[k] == a) return k;
        end
        return -1;
    endfunction

    // Apply one request at a falling edge, check the registered outputs one clock later.
    task automatic op(input bit lv, input logic [VC_ADDR_W-1:0] la,
                      input bit ev, input logic [VC_ADDR_W-1:0] ea,
                      input logic [VC_DATA_W-1:0] ed, input bit edt, input string tag);
        int hi, ej;
        bit e_hit, e_dirty, e_wb;
        logic [VC_DATA_W-1:0] e_data, e_wbd;
        logic [VC_ADDR_W-1:0] e_wba;
        hi = lv ? find(la) : -1;
        ej = ev ? find(ea) : -1;
        e_hit = (hi >= 0);
        e_data = e_hit ? m_d[hi] : '0;
        e_dirty = e_hit ? m_y[hi] : 1'b0;
        e_wb = 1'b0; e_wba = '0; e_wbd = '0;
        if (hi >= 0) m_v[hi] = 1'b0;
        if (ev) begin
            if (ej >= 0) begin
                m_v[ej] = 1'b1; m_d[ej] = ed; m_y[ej] = edt | m_y[ej];
            end else if (hi >= 0) begin
                m_v[hi] = 1'b1; m_a[hi] = ea; m_d[hi] = ed; m_y[hi] = edt;
            end else begin
                if (m_v[m_p] && m_y[m_p]) begin
                    e_wb = 1'b1; e_wba = m_a[m_p]; e_wbd = m_d[m_p];
                end
                m_v[m_p] = 1'b1; m_a[m_p] = ea; m_d[m_p] = ed; m_y[m_p] = edt;
                m_p = (m_p + 1) % N;
            end
        end
        lk_valid = lv; lk_addr = la;
        ev_valid = ev; ev_addr = ea; ev_data = ed; ev_dirty = edt;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0; ev_valid = 1'b0;
        chk(rsp_valid == lv, tag, "rsp_valid", 64'(rsp_valid), 64'(lv));
        if (lv) begin
            chk(rsp_hit == e_hit, tag, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
            chk(mem_req_valid == !e_hit, tag, "mem_req_valid", 64'(mem_req_valid), 64'(!e_hit));
            if (e_hit) begin
                chk(rsp_data == e_data, tag, "rsp_data", 64'(rsp_data), 64'(e_data));
                chk(rsp_dirty == e_dirty, tag, "rsp_dirty", 64'(rsp_dirty), 64'(e_dirty));
            end else begin
                chk(mem_req_addr == la, tag, "mem_req_addr", 64'(mem_req_addr), 64'(la));
            end
        end else begin
            chk(mem_req_valid == 1'b0, tag, "mem_req_valid", 64'(mem_req_valid), 64'd0);
        end
        chk(wb_valid == e_wb, tag, "wb_valid", 64'(wb_valid), 64'(e_wb));
        if (e_wb) begin
            chk(wb_addr == e_wba, tag, "wb_addr", 64'(wb_addr), 64'(e_wba));
            chk(wb_data == e_wbd, tag, "wb_data", 64'(wb_data), 64'(e_wbd));
        end
    endtask

    task automatic idle(input string tag);
        op(1'b0, '0, 1'b0, '0, '0, 1'b0, tag);
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin
            m_v[k] = 1'b0; m_y[k] = 1'b0; m_a[k] = '0; m_d[k] = '0;
        end
        m_p = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!rsp_valid && !rsp_hit && !mem_req_valid && !wb_valid, "R1", "outputs in reset",
            64'({rsp_valid, rsp_hit, mem_req_valid, wb_valid}), 64'd0);
        rst = 1'b0;

        op(1'b1, 16'h0010, 1'b0, '0, '0, 1'b0, "R1 R4 cold miss");
        idle("R11 R2 idle after miss");

        // Fill all four slots through the eviction port alone
        op(1'b0, '0, 1'b1, 16'h00a0, 32'h1111_0000, 1'b0, "R10 R7 insert a0");
        op(1'b0, '0, 1'b1, 16'h00a1, 32'h1111_0001, 1'b1, "R10 R7 insert a1 dirty");
        op(1'b0, '0, 1'b1, 16'h00a2, 32'h1111_0002, 1'b0, "R10 R7 insert a2");
        op(1'b0, '0, 1'b1, 16'h00a3, 32'h1111_0003, 1'b0, "R10 R7 insert a3");
        op(1'b1, 16'h00a2, 1'b0, '0, '0, 1'b0, "R3 hit slot 2");
        op(1'b1, 16'h00a1, 1'b0, '0, '0, 1'b0, "R3 hit dirty slot 1");
        op(1'b1, 16'h00a1, 1'b0, '0, '0, 1'b0, "R5 handed-out entry misses");
        op(1'b0, '0, 1'b1, 16'h00a1, 32'h2222_0001, 1'b1, "R7 reinsert a1 at slot 0");
        op(1'b0, '0, 1'b1, 16'h00a4, 32'h2222_0004, 1'b1, "R7 R8 insert into emptied slot 1");
        op(1'b0, '0, 1'b1, 16'h00a5, 32'h2222_0005, 1'b0, "R7 R8 insert into emptied slot 2");
        op(1'b0, '0, 1'b1, 16'h00a6, 32'h2222_0006, 1'b0, "R7 R8 clean push-out of a3");
        op(1'b0, '0, 1'b1, 16'h00a7, 32'h2222_0007, 1'b0, "R7 R8 dirty push-out of a1");
        chk(wb_addr == 16'h00a1 && wb_valid, "R8", "write-back of a1",
            64'(wb_addr), 64'h00a1);
        op(1'b1, 16'h00a3, 1'b0, '0, '0, 1'b0, "R7 oldest entry gone");
        op(1'b0, '0, 1'b1, 16'h00a5, 32'h3333_0005, 1'b1, "R9 merge a5 new data dirty");
        op(1'b0, '0, 1'b1, 16'h00a5, 32'h3333_0055, 1'b0, "R9 merge keeps dirty");
        op(1'b1, 16'h00a5, 1'b0, '0, '0, 1'b0, "R9 merged entry read");
        chk(rsp_data == 32'h3333_0055 && rsp_dirty, "R9", "merged data/flag",
            64'({rsp_dirty, rsp_data}), 64'h1_3333_0055);
        op(1'b1, 16'h00a6, 1'b1, 16'h00b0, 32'h4444_00b0, 1'b1, "R6 swap a6 for b0");
        op(1'b1, 16'h00b0, 1'b0, '0, '0, 1'b0, "R6 swapped-in block hit");
        op(1'b1, 16'h00c0, 1'b1, 16'h00c0, 32'h5555_00c0, 1'b0, "R4 R7 miss with same-address insert");
        idle("R11 pulses end");

        for (int n = 0; n < 3000; n++) begin
            bit lv, ev, dt;
            logic [VC_ADDR_W-1:0] la, ea;
            logic [VC_DATA_W-1:0] dd;
            lv = ($urandom % 4) != 0;
            ev = ($urandom % 2) != 0;
            dt = ($urandom % 2) != 0;
            la = VC_ADDR_W'($urandom % 12);
            ea = VC_ADDR_W'($urandom % 12);
            dd = $urandom;
            if (($urandom % 16) == 0) idle("R11 random idle");
            op(lv, la, ev, ea, dd, dt, "R2 R3 R4 R6 R8 R9 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule